// File: doc/BRIEF.md
# Pipeline Operand Forwarding Unit

This block resolves read-after-write data hazards in a five-stage in-order integer pipeline without stalling. Each cycle it compares the two source register numbers of the instruction in the execute stage against the destination numbers carried by the memory and writeback stages. For each ALU input it produces a two-bit select code. The code picks the register-file value read earlier, the memory-stage ALU result, or the writeback-stage result. A small operand multiplexer per ALU input applies that code, so the selected operand is visible at the ports.

The block also holds the integer register file: 32 entries of 32 bits, two read ports for the decode stage and one write port fed by the writeback stage. When the decode stage reads a register that writeback is writing in the same cycle, the read port returns the value being written instead of the old contents. Register 0 is hard-wired to zero. Load-use stalls, branch resolution and data memory sit outside this block.

Top module: `fwd_unit`

## Requirements
- R1: Each operand select uses the code 2'b00 for the register-file operand, 2'b10 for the memory-stage result and 2'b01 for the writeback-stage result. The matching ALU operand output carries the value the code selects.
- R2: When the memory stage has its write enable set, a nonzero destination, and a destination equal to an execute source, that operand's select is 2'b10.
- R3: When only the writeback stage has its write enable set, a nonzero destination, and a destination equal to an execute source, that operand's select is 2'b01.
- R4: When both later stages qualify for the same source, the memory-stage result wins and the select is 2'b10.
- R5: A stage whose write enable is low, or whose destination is register 0, never causes forwarding. With no qualifying producer the select is 2'b00.
- R6: The two operand selects are computed independently, so each operand may take a different source in the same cycle.
- R7: A writeback write with a nonzero destination is stored at the clock edge and can be read on both decode read ports from the next cycle on.
- R8: When a decode read address equals the writeback destination, the write enable is set and the destination is nonzero, that read port returns the write data in the same cycle. With the write enable low there is no bypass.
- R9: Register 0 always reads as zero on both read ports. A write to it is neither stored nor bypassed.
- R10: Reset clears every register to zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, clears the register file |
| ex_rs1 | input | 5 | Execute-stage first source register number |
| ex_rs2 | input | 5 | Execute-stage second source register number |
| ex_rf_a | input | 32 | First operand as read from the register file |
| ex_rf_b | input | 32 | Second operand as read from the register file |
| mem_rd | input | 5 | Memory-stage destination register number |
| mem_we | input | 1 | Memory-stage register write enable |
| mem_result | input | 32 | Memory-stage ALU result |
| wb_rd | input | 5 | Writeback-stage destination, also the register-file write address |
| wb_we | input | 1 | Writeback-stage write enable, also the register-file write enable |
| wb_result | input | 32 | Writeback-stage result, also the register-file write data |
| id_ra1 | input | 5 | Decode-stage first read address |
| id_ra2 | input | 5 | Decode-stage second read address |
| fwd_a_sel | output | 2 | Select code for the first ALU operand |
| fwd_b_sel | output | 2 | Select code for the second ALU operand |
| alu_a | output | 32 | Selected first ALU operand |
| alu_b | output | 32 | Selected second ALU operand |
| rd_data1 | output | 32 | Decode read data, port 1, with write bypass |
| rd_data2 | output | 32 | Decode read data, port 2, with write bypass |

## Verification
The selects and operand multiplexers are pure combinational logic. A wrong priority or a missing register-0 qualifier shows up at fwd_a_sel, fwd_b_sel and the ALU operands in the same cycle as the offending stage contents. The register array is the only state. A write that lands at the wrong address, or is dropped, surfaces at a read port one cycle after the writeback edge. A broken bypass shows up during the writing cycle itself. The stimulus therefore reads back each written location on the cycle after the write, and also reads it during the write.

// File: rtl/fwd_pkg.sv
package fwd_pkg;
    localparam int NREG = 32;
    localparam int XLEN = 32;
    localparam int AW   = $clog2(NREG);
    localparam int NOPS = 2;

    typedef enum logic [1:0] {
        SEL_RF  = 2'b00,
        SEL_WB  = 2'b01,
        SEL_MEM = 2'b10
    } fwd_sel_e;
endpackage

// File: rtl/fwd_select.sv
module fwd_select
    import fwd_pkg::*;
#(
    parameter int AW_P = AW
) (
    input  logic [AW_P-1:0] src,
    input  logic [AW_P-1:0] mem_rd,
    input  logic            mem_we,
    input  logic [AW_P-1:0] wb_rd,
    input  logic            wb_we,
    output fwd_sel_e        sel
);
    logic mem_hit;
    logic wb_hit;

    always_comb begin
        mem_hit = mem_we && (mem_rd != '0) && (mem_rd == src);
        wb_hit  = wb_we  && (wb_rd  != '0) && (wb_rd  == src);
        // younger producer wins
        if (mem_hit)     sel = SEL_MEM;
        else if (wb_hit) sel = SEL_WB;
        else             sel = SEL_RF;
    end
endmodule

// File: rtl/opnd_mux.sv
module opnd_mux
    import fwd_pkg::*;
#(
    parameter int W = XLEN
) (
    input  fwd_sel_e       sel,
    input  logic [W-1:0]   rf_val,
    input  logic [W-1:0]   mem_val,
    input  logic [W-1:0]   wb_val,
    output logic [W-1:0]   opnd
);
    always_comb begin
        case (sel)
            SEL_MEM: opnd = mem_val;
            SEL_WB:  opnd = wb_val;
            default: opnd = rf_val;
        endcase
    end
endmodule

// File: rtl/regfile_bypass.sv
module regfile_bypass
    import fwd_pkg::*;
#(
    parameter int N     = NREG,
    parameter int W     = XLEN,
    parameter int NRD   = NOPS,
    localparam int A    = $clog2(N)
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         we,
    input  logic [A-1:0] wa,
    input  logic [W-1:0] wd,
    input  logic [A-1:0] ra [NRD],
    output logic [W-1:0] rd [NRD]
);
    typedef struct packed {
        logic [N-1:0][W-1:0] regs;
    } rf_state_t;

    rf_state_t st_d;
    rf_state_t st_q;
    logic      wr_ok;

    always_comb begin
        wr_ok = we && (wa != '0);
        st_d  = st_q;
        if (wr_ok) st_d.regs[wa] = wd;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    for (genvar p = 0; p < NRD; p++) begin : g_rd
        always_comb begin
            if (ra[p] == '0)                rd[p] = '0;
            else if (wr_ok && wa == ra[p])  rd[p] = wd;
            else                            rd[p] = st_q.regs[ra[p]];
        end
    end
endmodule

// File: rtl/fwd_unit.sv
module fwd_unit
    import fwd_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic [AW-1:0]   ex_rs1,
    input  logic [AW-1:0]   ex_rs2,
    input  logic [XLEN-1:0] ex_rf_a,
    input  logic [XLEN-1:0] ex_rf_b,
    input  logic [AW-1:0]   mem_rd,
    input  logic            mem_we,
    input  logic [XLEN-1:0] mem_result,
    input  logic [AW-1:0]   wb_rd,
    input  logic            wb_we,
    input  logic [XLEN-1:0] wb_result,
    input  logic [AW-1:0]   id_ra1,
    input  logic [AW-1:0]   id_ra2,
    output logic [1:0]      fwd_a_sel,
    output logic [1:0]      fwd_b_sel,
    output logic [XLEN-1:0] alu_a,
    output logic [XLEN-1:0] alu_b,
    output logic [XLEN-1:0] rd_data1,
    output logic [XLEN-1:0] rd_data2
);
    logic [AW-1:0]   src   [NOPS];
    logic [XLEN-1:0] rfv   [NOPS];
    fwd_sel_e        sel   [NOPS];
    logic [XLEN-1:0] opnd  [NOPS];
    logic [AW-1:0]   raddr [NOPS];
    logic [XLEN-1:0] rdata [NOPS];

    assign src[0]   = ex_rs1;
    assign src[1]   = ex_rs2;
    assign rfv[0]   = ex_rf_a;
    assign rfv[1]   = ex_rf_b;
    assign raddr[0] = id_ra1;
    assign raddr[1] = id_ra2;

    for (genvar i = 0; i < NOPS; i++) begin : g_op
        fwd_select #(.AW_P(AW)) u_sel (
            .src    (src[i]),
            .mem_rd (mem_rd),
            .mem_we (mem_we),
            .wb_rd  (wb_rd),
            .wb_we  (wb_we),
            .sel    (sel[i])
        );
        opnd_mux #(.W(XLEN)) u_mux (
            .sel     (sel[i]),
            .rf_val  (rfv[i]),
            .mem_val (mem_result),
            .wb_val  (wb_result),
            .opnd    (opnd[i])
        );
    end

    regfile_bypass #(.N(NREG), .W(XLEN), .NRD(NOPS)) u_rf (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (wb_we),
        .wa    (wb_rd),
        .wd    (wb_result),
        .ra    (raddr),
        .rd    (rdata)
    );

    assign fwd_a_sel = sel[0];
    assign fwd_b_sel = sel[1];
    assign alu_a     = opnd[0];
    assign alu_b     = opnd[1];
    assign rd_data1  = rdata[0];
    assign rd_data2  = rdata[1];
endmodule

// File: rtl/fwd_unit_chk.sv
module fwd_unit_chk
    import fwd_pkg::*;
(
    input logic            clk,
    input logic            rst_n,
    input logic [AW-1:0]   ex_rs1,
    input logic [AW-1:0]   ex_rs2,
    input logic [AW-1:0]   mem_rd,
    input logic            mem_we,
    input logic [XLEN-1:0] mem_result,
    input logic [AW-1:0]   wb_rd,
    input logic            wb_we,
    input logic [XLEN-1:0] wb_result,
    input logic [AW-1:0]   id_ra1,
    input logic [1:0]      fwd_a_sel,
    input logic [1:0]      fwd_b_sel,
    input logic [XLEN-1:0] alu_a,
    input logic [XLEN-1:0] rd_data1,
    input logic [XLEN-1:0] rd_data2
);
    logic seen;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) seen <= 1'b0;
        else        seen <= 1'b1;
    end

    a_r2_mem_fwd_a: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_we && mem_rd != '0 && mem_rd == ex_rs1) |-> fwd_a_sel == 2'b10);

    a_r4_mem_wins_b: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_we && wb_we && mem_rd != '0 && mem_rd == ex_rs2 && wb_rd == ex_rs2)
        |-> fwd_b_sel == 2'b10);

    a_r3_wb_fwd_a: assert property (@(posedge clk) disable iff (!rst_n)
        (wb_we && wb_rd != '0 && wb_rd == ex_rs1 && !(mem_we && mem_rd == ex_rs1))
        |-> fwd_a_sel == 2'b01);

    a_r5_reg0_a: assert property (@(posedge clk) disable iff (!rst_n)
        (ex_rs1 == '0) |-> fwd_a_sel == 2'b00);

    a_r1_mux_mem: assert property (@(posedge clk) disable iff (!rst_n)
        (fwd_a_sel == 2'b10) |-> alu_a == mem_result);

    a_r8_bypass1: assert property (@(posedge clk) disable iff (!rst_n)
        (wb_we && wb_rd != '0 && wb_rd == id_ra1) |-> rd_data1 == wb_result);

    a_r9_zero_read: assert property (@(posedge clk) disable iff (!rst_n)
        (id_ra1 == '0) |-> rd_data1 == '0);

    a_r7_write_lands: assert property (@(posedge clk) disable iff (!rst_n)
        (seen && $past(wb_we) && $past(wb_rd) != '0 && id_ra1 == $past(wb_rd)
         && !(wb_we && wb_rd == id_ra1)) |-> rd_data1 == $past(wb_result));

    always_comb begin
        if (rst_n && fwd_b_sel == 2'b11) begin
            a_r1_code_b: assert (1'b0);
        end
    end

    logic unused;
    assign unused = ^rd_data2;
endmodule

bind fwd_unit fwd_unit_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .ex_rs1     (ex_rs1),
    .ex_rs2     (ex_rs2),
    .mem_rd     (mem_rd),
    .mem_we     (mem_we),
    .mem_result (mem_result),
    .wb_rd      (wb_rd),
    .wb_we      (wb_we),
    .wb_result  (wb_result),
    .id_ra1     (id_ra1),
    .fwd_a_sel  (fwd_a_sel),
    .fwd_b_sel  (fwd_b_sel),
    .alu_a      (alu_a),
    .rd_data1   (rd_data1),
    .rd_data2   (rd_data2)
);

// File: tb/fwd_unit_bench.sv
`timescale 1ns/1ps
module fwd_unit_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [4:0]  ex_rs1 = '0, ex_rs2 = '0, mem_rd = '0, wb_rd = '0;
    logic [4:0]  id_ra1 = '0, id_ra2 = '0;
    logic        mem_we = 1'b0, wb_we = 1'b0;
    logic [31:0] ex_rf_a = 32'hAAAA0001, ex_rf_b = 32'hBBBB0002;
    logic [31:0] mem_result = 32'h11110000, wb_result = 32'h22220000;
    logic [1:0]  fwd_a_sel, fwd_b_sel;
    logic [31:0] alu_a, alu_b, rd_data1, rd_data2;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    fwd_unit u_fwd_unit (.*);

    // {rs1, rs2, mem_rd, mem_we, wb_rd, wb_we, exp_a, exp_b}
    localparam logic [25:0] VEC [12] = '{
        {5'd3,  5'd4,  5'd3,  1'b0, 5'd4,  1'b0, 2'b00, 2'b00},
        {5'd3,  5'd4,  5'd3,  1'b1, 5'd0,  1'b0, 2'b10, 2'b00},
        {5'd3,  5'd4,  5'd0,  1'b0, 5'd4,  1'b1, 2'b00, 2'b01},
        {5'd7,  5'd9,  5'd7,  1'b1, 5'd7,  1'b1, 2'b10, 2'b00},
        {5'd7,  5'd9,  5'd7,  1'b1, 5'd9,  1'b1, 2'b10, 2'b01},
        {5'd0,  5'd0,  5'd0,  1'b1, 5'd0,  1'b1, 2'b00, 2'b00},
        {5'd12, 5'd12, 5'd12, 1'b1, 5'd11, 1'b1, 2'b10, 2'b10},
        {5'd12, 5'd12, 5'd5,  1'b1, 5'd12, 1'b1, 2'b01, 2'b01},
        {5'd6,  5'd8,  5'd6,  1'b0, 5'd6,  1'b1, 2'b01, 2'b00},
        {5'd31, 5'd31, 5'd31, 1'b1, 5'd31, 1'b0, 2'b10, 2'b10},
        {5'd1,  5'd2,  5'd2,  1'b1, 5'd1,  1'b1, 2'b01, 2'b10},
        {5'd1,  5'd2,  5'd3,  1'b1, 5'd4,  1'b1, 2'b00, 2'b00}
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] pick(input logic [1:0] s, input logic [31:0] rf);
        case (s)
            2'b10:   return mem_result;
            2'b01:   return wb_result;
            default: return rf;
        endcase
    endfunction

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;

        // R10: reset contents
        id_ra1 = 5'd5; id_ra2 = 5'd31;
        #1;
        chk("R10 reset reg5", rd_data1, 32'h0);
        chk("R10 reset reg31", rd_data2, 32'h0);

        // vector table: R1..R6
        for (int i = 0; i < 12; i++) begin
            @(negedge clk);
            ex_rs1 = VEC[i][25:21]; ex_rs2 = VEC[i][20:16];
            mem_rd = VEC[i][15:11]; mem_we = VEC[i][10];
            wb_rd  = VEC[i][9:5];   wb_we  = VEC[i][4];
            #1;
            chk("R2/R3/R4/R5 sel a", {30'd0, fwd_a_sel}, {30'd0, VEC[i][3:2]});
            chk("R6 sel b", {30'd0, fwd_b_sel}, {30'd0, VEC[i][1:0]});
            chk("R1 alu_a", alu_a, pick(VEC[i][3:2], ex_rf_a));
            chk("R1 alu_b", alu_b, pick(VEC[i][1:0], ex_rf_b));
        end

        // R8: same-cycle bypass into reg 10, R7: stored afterwards
        @(negedge clk);
        mem_we = 1'b0; wb_we = 1'b1; wb_rd = 5'd10; wb_result = 32'hCAFE0010;
        id_ra1 = 5'd10; id_ra2 = 5'd5;
        #1;
        chk("R8 bypass port1", rd_data1, 32'hCAFE0010);
        chk("R8 unrelated port2", rd_data2, 32'h0);
        @(negedge clk);
        wb_we = 1'b0; wb_result = 32'h0BAD0BAD; id_ra1 = 5'd10; id_ra2 = 5'd10;
        #1;
        chk("R7 stored port1", rd_data1, 32'hCAFE0010);
        chk("R7 stored port2", rd_data2, 32'hCAFE0010);

        // R8: no bypass when write enable low
        wb_rd = 5'd5; id_ra2 = 5'd5;
        #1;
        chk("R8 no bypass we=0", rd_data2, 32'h0);

        // R9: write to register 0 ignored
        @(negedge clk);
        wb_we = 1'b1; wb_rd = 5'd0; wb_result = 32'hFFFFFFFF;
        id_ra1 = 5'd0; id_ra2 = 5'd0;
        #1;
        chk("R9 reg0 not bypassed", rd_data1, 32'h0);
        @(negedge clk);
        wb_we = 1'b0;
        #1;
        chk("R9 reg0 not stored", rd_data2, 32'h0);

        // R7: overwrite and second location
        @(negedge clk);
        wb_we = 1'b1; wb_rd = 5'd5; wb_result = 32'h00005005;
        @(negedge clk);
        wb_we = 1'b0; id_ra1 = 5'd5; id_ra2 = 5'd10;
        #1;
        chk("R7 reg5 stored", rd_data1, 32'h00005005);
        chk("R7 reg10 kept", rd_data2, 32'hCAFE0010);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog all requirements actual=hung expected=done");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end
endmodule